// File: doc/BRIEF.md
# Masked Content-Addressable Memory Array

This block holds a small table of `WORDS` entries, each `WIDTH` bits wide. On a search command it compares an argument against every entry in the same cycle. A key supplied with the search selects which bit columns take part, and only entries flagged as active can report a hit. The result is a per-entry hit vector that is held until the next search. Entries are loaded in one of two ways. An addressed write stores data at a binary index. An insert stores data in the lowest-numbered inactive entry. A delete retires an entry.

Two ways of reading are provided. The first is a combinational hit word: the OR of all entries that currently match the last argument and key. With unique, nonzero contents this word is the matched entry, or zero when nothing matches. The second is a scan command, which walks the captured hit vector and presents one hit per cycle in ascending index order, then signals completion. The scan controller has three states:
- `ST_IDLE` accepts commands.
- A scan command moves it to `ST_WALK` if any hit bit is set, and to `ST_FIN` otherwise.
- `ST_WALK` presents the lowest pending hit and retires it. It stays in `ST_WALK` while further hits remain, and moves to `ST_FIN` when the retired hit was the last one.
- `ST_FIN` raises the done strobe for one cycle and returns to `ST_IDLE`.

Commands are encoded on `cmd_op` as follows: 0 none, 1 addressed write, 2 insert, 3 delete, 4 search, 5 scan. Every command takes effect at the clock edge where `cmd_valid` is high and the controller is in `ST_IDLE`.

Top module: `cam_array`

## Requirements
- R1: In a search, entry i hits only if, for every bit position j where `cmd_key[j]` is 1, the stored bit equals `cmd_data[j]`; positions with key bit 0 are disregarded. The hit vector appears on `match_vec` in the cycle after the search command.
- R2: A single differing bit in any keyed column removes the hit, so a full key (all ones) hits only on exact equality.
- R3: A search whose key is all zeros sets `key_err` (held until the next search) and makes every active entry hit.
- R4: An inactive entry never hits, whatever its contents, argument or key.
- R5: An insert writes to the lowest-indexed inactive entry and makes it active.
- R6: An insert when every entry is active pulses `full_err` for one cycle and leaves all contents and active flags unchanged.
- R7: A delete (op 3) makes the addressed entry inactive, clears its bit in `match_vec` and frees the entry for a later insert.
- R8: An addressed write (op 1) stores `cmd_data` at entry `cmd_addr` and makes it active.
- R9: A scan (op 5) presents, one per cycle with `scan_valid` high, the index and contents of each hit in ascending order. `scan_done` is raised for one cycle in the cycle after the last hit, or in the cycle after the command when there is no hit.
- R10: `hit_word` equals the stored contents of the single entry matching the last search's argument and key, and is zero when no entry matches.
- R11: After reset all entries are inactive, `match_vec`, `key_err`, `full_err` and `hit_word` are zero, and the controller is idle.
- R12: While `busy` is high (during a scan), commands have no effect on contents, active flags or `match_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 none, 1 write, 2 insert, 3 delete, 4 search, 5 scan) |
| cmd_addr | input | $clog2(WORDS) | Entry index for write and delete |
| cmd_data | input | WIDTH | Write/insert data, or search argument |
| cmd_key | input | WIDTH | Column enable key for search |
| match_vec | output | WORDS | Captured hit vector of the last search |
| key_err | output | 1 | Last search used an all-zero key |
| full_err | output | 1 | One-cycle pulse: insert refused, table full |
| hit_word | output | WIDTH | OR of entries matching the last argument and key |
| busy | output | 1 | Scan in progress; commands ignored |
| scan_valid | output | 1 | Scan presents a hit this cycle |
| scan_idx | output | $clog2(WORDS) | Index of the presented hit |
| scan_word | output | WIDTH | Contents of the presented hit |
| scan_done | output | 1 | One-cycle pulse: scan finished |

## Verification
The assertions assume that `cmd_addr` stays below `WORDS`. They also assume that the hit vector cannot change while a scan walks it, because commands are dropped when `busy` is high. The stimulus only issues indices inside the table. It relies on `hit_word` only after searches that the bench model predicts to hit at most one entry, and it stores only nonzero, distinct values before those checks. Commands injected during a scan are deliberate. They exist to show that the ignore rule keeps the captured hit vector and the contents intact.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_INSERT = 3'd2,
        OP_DELETE = 3'd3,
        OP_SEARCH = 3'd4,
        OP_SCAN   = 3'd5
    } cam_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_FIN
    } scan_st_e;
endpackage

// File: rtl/cam_row.sv
module cam_row #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] key,
    input  logic             active,
    output logic             hit
);
    logic [WIDTH-1:0] col_ok;

    // per-column term: equal, or column not keyed
    for (genvar j = 0; j < WIDTH; j++) begin : g_col
        assign col_ok[j] = (word[j] ~^ arg[j]) | ~key[j];
    end

    assign hit = active & (&col_ok);
endmodule

// File: rtl/cam_lowest.sv
module cam_lowest #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [AW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/cam_array.sv
module cam_array
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [WIDTH-1:0] cmd_data,
    input  logic [WIDTH-1:0] cmd_key,
    output logic [WORDS-1:0] match_vec,
    output logic             key_err,
    output logic             full_err,
    output logic [WIDTH-1:0] hit_word,
    output logic             busy,
    output logic             scan_valid,
    output logic [AW-1:0]    scan_idx,
    output logic [WIDTH-1:0] scan_word,
    output logic             scan_done
);
    logic [WIDTH-1:0] mem_q [WORDS];
    logic [WORDS-1:0] active_q, match_q, pend_q;
    logic [WORDS-1:0] cap_hit, live_hit, free_vec;
    logic [WIDTH-1:0] arg_q, key_q;
    logic             key_err_q, full_err_q;
    logic [AW-1:0]    free_idx, next_idx;
    logic             free_ok, next_ok;
    scan_st_e         state_q, state_d;
    cam_op_e          op;
    logic             accept;

    assign op       = cam_op_e'(cmd_op);
    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign free_vec = ~active_q;

    for (genvar i = 0; i < WORDS; i++) begin : g_row
        cam_row #(.WIDTH(WIDTH)) u_cap (
            .word(mem_q[i]), .arg(cmd_data), .key(cmd_key),
            .active(active_q[i]), .hit(cap_hit[i])
        );
        cam_row #(.WIDTH(WIDTH)) u_live (
            .word(mem_q[i]), .arg(arg_q), .key(key_q),
            .active(active_q[i]), .hit(live_hit[i])
        );
    end

    cam_lowest #(.N(WORDS), .AW(AW)) u_free (
        .vec(free_vec), .idx(free_idx), .found(free_ok)
    );
    cam_lowest #(.N(WORDS), .AW(AW)) u_next (
        .vec(pend_q), .idx(next_idx), .found(next_ok)
    );

    // table contents, flags and captured hits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
            active_q   <= '0;
            match_q    <= '0;
            arg_q      <= '0;
            key_q      <= '0;
            key_err_q  <= 1'b0;
            full_err_q <= 1'b0;
        end else begin
            full_err_q <= accept && (op == OP_INSERT) && !free_ok;
            if (accept) begin
                case (op)
                    OP_WRITE: begin
                        mem_q[cmd_addr]    <= cmd_data;
                        active_q[cmd_addr] <= 1'b1;
                    end
                    OP_INSERT: begin
                        if (free_ok) begin
                            mem_q[free_idx]    <= cmd_data;
                            active_q[free_idx] <= 1'b1;
                        end
                    end
                    OP_DELETE: begin
                        mem_q[cmd_addr]    <= '0;
                        active_q[cmd_addr] <= 1'b0;
                        match_q[cmd_addr]  <= 1'b0;
                    end
                    OP_SEARCH: begin
                        arg_q     <= cmd_data;
                        key_q     <= cmd_key;
                        match_q   <= cap_hit;
                        key_err_q <= (cmd_key == '0);
                    end
                    default: ;
                endcase
            end
        end
    end

    // scan state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pending hits walked by the scan
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (accept && op == OP_SCAN) begin
            pend_q <= match_q;
        end else if (state_q == ST_WALK) begin
            pend_q <= pend_q & ~(WORDS'(1) << next_idx);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && op == OP_SCAN)
                         state_d = (match_q != '0) ? ST_WALK : ST_FIN;
            ST_WALK: if ((pend_q & (pend_q - WORDS'(1))) == '0)
                         state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        scan_valid = (state_q == ST_WALK) && next_ok;
        scan_done  = (state_q == ST_FIN);
        scan_idx   = next_idx;
        scan_word  = mem_q[next_idx];
        match_vec  = match_q;
        key_err    = key_err_q;
        full_err   = full_err_q;
        hit_word   = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (live_hit[i]) hit_word = hit_word | mem_q[i];
        end
    end

    assert_inactive_nohit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ~active_q) == '0);

    assert_zero_key_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_SEARCH && cmd_key == '0) |=> (key_err && match_vec == active_q));

    assert_full_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_INSERT && active_q == '1) |=> (full_err && $stable(active_q)));

    assert_insert_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_INSERT && active_q != '1)
        |=> ($countones(active_q) == $countones($past(active_q)) + 1));

    assert_scan_is_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> match_vec[scan_idx]);

    assert_scan_ascend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && $past(scan_valid)) |-> (scan_idx > $past(scan_idx)));

    assert_busy_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(active_q) && $stable(match_vec)));
endmodule

// File: tb/test_cam_array.sv
module test_cam_array;
    localparam int N      = 8;
    localparam int W      = 8;
    localparam int AW     = 3;
    localparam int CLK_NS = 10;
    localparam int WD_CYC = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [W-1:0]  cmd_data = '0;
    logic [W-1:0]  cmd_key = '0;
    logic [N-1:0]  match_vec;
    logic          key_err, full_err, busy, scan_valid, scan_done;
    logic [W-1:0]  hit_word, scan_word;
    logic [AW-1:0] scan_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [W-1:0] mdl_mem [N];
    logic [N-1:0] mdl_act = '0;
    logic [N-1:0] mdl_match = '0;
    logic [W-1:0] words [N];

    always #(CLK_NS/2) clk = ~clk;

    cam_array #(.WORDS(N), .WIDTH(W)) i_cam_array (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_key(cmd_key),
        .match_vec(match_vec), .key_err(key_err), .full_err(full_err),
        .hit_word(hit_word), .busy(busy), .scan_valid(scan_valid),
        .scan_idx(scan_idx), .scan_word(scan_word), .scan_done(scan_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_hits(input logic [W-1:0] a, input logic [W-1:0] k);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = mdl_act[i] && (((mdl_mem[i] ^ a) & k) == '0);
        return r;
    endfunction

    function automatic logic [W-1:0] exp_word(input logic [N-1:0] h);
        logic [W-1:0] r = '0;
        for (int i = 0; i < N; i++) if (h[i]) r = r | mdl_mem[i];
        return r;
    endfunction

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [W-1:0] d, input logic [W-1:0] k);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_key = k;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic search(input logic [W-1:0] a, input logic [W-1:0] k, input string req);
        logic [N-1:0] e;
        e = exp_hits(a, k);
        issue(3'd4, '0, a, k);
        mdl_match = e;
        chk(match_vec == e, req, match_vec, e);
        chk(key_err == (k == '0), {req, " key_err"}, key_err, (k == '0));
        if ($countones(e) <= 1)
            chk(hit_word == exp_word(e), {req, " R10 hit_word"}, hit_word, exp_word(e));
    endtask

    task automatic insert(input logic [W-1:0] d);
        int slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!mdl_act[i]) slot = i;
        issue(3'd2, '0, d, '0);
        if (slot >= 0) begin
            mdl_mem[slot] = d; mdl_act[slot] = 1'b1;
        end
        chk(full_err == (slot < 0), "R5/R6 full_err", full_err, (slot < 0));
    endtask

    task automatic scan(input bit inject);
        logic [N-1:0] e;
        e = mdl_match;
        issue(3'd5, '0, '0, '0);
        if (inject) begin
            cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = '0;
        end
        for (int i = 0; i < N; i++) begin
            if (e[i]) begin
                chk(scan_valid && scan_idx == AW'(i) && !scan_done, "R9 scan step",
                    {scan_valid, 3'b0, 4'(scan_idx)}, {1'b1, 3'b0, 4'(i)});
                chk(scan_word == mdl_mem[i], "R9 scan word", scan_word, mdl_mem[i]);
                @(posedge clk); #1;
            end
        end
        chk(scan_done && !scan_valid, "R9 scan done", {scan_done, scan_valid}, 2'b10);
        cmd_valid = 1'b0;
        @(posedge clk); #1;
        chk(!busy && !scan_done, "R9 back idle", {busy, scan_done}, 2'b00);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mdl_mem[i] = '0;
            words[i] = W'(i * 37 + 5);
        end
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(match_vec == '0 && !key_err && !full_err && !busy && !scan_valid && !scan_done,
            "R11 reset flags", {match_vec, key_err, full_err, busy}, '0);
        chk(hit_word == '0, "R11 reset hit_word", hit_word, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R4: zero contents but inactive never hit
        search('0, '1, "R4 inactive empty");
        search('0, '0, "R4 inactive zero key");

        // R5: fill by insert; each lands in the lowest free slot
        for (int i = 0; i < N; i++) begin
            insert(words[i]);
            search(words[i], '1, "R5 insert slot");
            chk(match_vec == (N'(1) << i), "R5 slot index", match_vec, N'(1) << i);
        end

        // R6: insert on full table
        insert(8'hEE);
        for (int i = 0; i < N; i++) search(words[i], '1, "R6 unchanged");

        // R1 R2 R3: key sweep over several arguments
        for (int a = 0; a < 4; a++) begin
            logic [W-1:0] arg;
            arg = (a == 0) ? words[2] : (a == 1) ? 8'h00 : (a == 2) ? 8'hFF : 8'hA5;
            for (int k = 0; k < 256; k++) search(arg, W'(k), "R1 R2 R3 masked sweep");
        end
        // R2: one flipped bit under full key
        for (int b = 0; b < W; b++) search(words[4] ^ (W'(1) << b), '1, "R2 single bit off");

        // R7: delete two entries
        issue(3'd3, AW'(3), '0, '0); mdl_act[3] = 1'b0; mdl_mem[3] = '0;
        issue(3'd3, AW'(5), '0, '0); mdl_act[5] = 1'b0; mdl_mem[5] = '0;
        search('0, '0, "R7 after delete");
        search(words[3], '1, "R7 deleted no hit");
        search('0, '1, "R7 cleared word no hit");
        insert(8'h5A);
        search(8'h5A, '1, "R7 R5 reuse slot 3");
        insert(8'hC3);
        search(8'hC3, '1, "R7 R5 reuse slot 5");

        // R8: addressed write
        issue(3'd1, AW'(6), 8'h3C, '0); mdl_mem[6] = 8'h3C; mdl_act[6] = 1'b1;
        search(8'h3C, '1, "R8 addressed write");
        issue(3'd3, AW'(1), '0, '0); mdl_act[1] = 1'b0; mdl_mem[1] = '0;
        issue(3'd1, AW'(1), 8'h81, '0); mdl_mem[1] = 8'h81; mdl_act[1] = 1'b1;
        search(8'h81, '1, "R8 write reactivates");

        // R9: multi-hit scan
        search(8'h01, 8'h01, "R9 setup odd");
        scan(1'b0);
        search(8'h00, 8'h01, "R9 setup even");
        scan(1'b0);
        // R12: delete injected during scan has no effect
        search('0, '0, "R12 setup all");
        scan(1'b1);
        chk(match_vec == mdl_match, "R12 match kept", match_vec, mdl_match);
        search('0, '0, "R12 actives kept");
        // R9: scan with no hits
        search(8'h77, '1, "R9 setup none");
        scan(1'b0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule